// File: doc/BRIEF.md
# Partitioned CAN Acceptance Filter Bank

This block decides, for every received CAN or CAN FD frame header, whether the frame is kept and which of two receive FIFOs takes it. It holds a bank of filter slots. Each slot has a mask word and an identifier word, and software writes both through a small write-only register port. When the receiver presents a decoded header with a one-cycle valid strobe, every enabled slot compares the header with its identifier word. Only the bits that its mask word selects take part in that compare.

A partition index splits the bank into a lower group that feeds FIFO 0 and an upper group that feeds FIFO 1. When several slots match, the lowest-numbered matching slot decides the target FIFO. One clock after the strobe, the block gives one of two results:

- a store pulse, with the FIFO select and the slot index;
- a drop pulse, when the target FIFO is full.

A frame that is dropped never falls back to the other FIFO.

Top module: `canf_accept_filter`

## Requirements
- R1: After synchronous reset, store_o and drop_o are low and every mask and identifier word reads as zero. A zero mask word accepts any header, so an enabled slot that has not been written matches every frame.
- R2: Filter words, and the header, use a 32-bit layout: bits 31:21 hold the base identifier, bit 20 SRR, bit 19 IDE, bits 18:1 the extended identifier and bit 0 RTR. A header matches a slot when every bit whose mask bit is 1 equals the identifier-word bit. Mask bits of 0 are ignored.
- R3: When bit 19 (IDE) of a slot's mask word is 0, the slot compares only the masked base-identifier bits 31:21. The SRR, IDE, extended and RTR fields of the header have no effect on the result.
- R4: A slot whose enable bit in flt_en is 0 never matches. With flt_en all zero, no frame produces a store or a drop.
- R5: When more than one enabled slot matches, the lowest-numbered one is selected and its index appears on hit_idx_o with the store or drop pulse.
- R6: A selected slot with index below part_idx routes to FIFO 0 (fifo_sel_o = 0); any other index routes to FIFO 1. A part_idx of 0 sends all matches to FIFO 1. A part_idx of NFILT or above sends all matches to FIFO 0.
- R7: If the target FIFO's full flag is high in the strobe cycle, drop_o pulses instead of store_o. The frame is not redirected, even if the other FIFO has room.
- R8: store_o or drop_o rises in the clock after frm_valid is sampled, lasts one cycle, and is never high together with the other. Neither pulses without a preceding strobe. Back-to-back strobes each produce their own result.
- R9: A write at byte address 0x0A00 + 8*j updates the mask word of slot j, and a write at 0x0A04 + 8*j updates its identifier word. Writes outside 0x0A00 to 0x0A00 + 8*NFILT - 4 are ignored, and so are writes with address bits 1:0 not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| frm_valid | input | 1 | Header valid strobe, one cycle per frame |
| frm_base | input | 11 | Base identifier |
| frm_srr | input | 1 | SRR bit |
| frm_ide | input | 1 | IDE bit |
| frm_ext | input | 18 | Extended identifier |
| frm_rtr | input | 1 | RTR bit |
| flt_en | input | 32 | Per-slot enable |
| part_idx | input | 6 | Partition index |
| fifo0_full | input | 1 | FIFO 0 full flag |
| fifo1_full | input | 1 | FIFO 1 full flag |
| store_o | output | 1 | Store pulse |
| fifo_sel_o | output | 1 | Target FIFO of the reported result |
| hit_idx_o | output | 5 | Index of the selected slot |
| drop_o | output | 1 | Drop pulse |

## Verification

The bench programs a standard-only slot and then sends headers that differ from it only in the extended, SRR, IDE and RTR fields. A design that compared those fields anyway would lose these frames.

It lets two slots match at once to expose a wrong priority order, which would report the higher index or pick the wrong FIFO. It also sets part_idx to 0, to a mid value and to NFILT, to catch an off-by-one at the partition boundary.

With the target FIFO full and the other one free, a design with a fallback would store the frame instead of dropping it. Writes to unaligned and out-of-bank addresses are followed by frames that would reveal a corrupted slot. A long stretch of back-to-back random frames shows whether any result is lost or duplicated.

// File: rtl/canf_pkg.sv
package canf_pkg;

    localparam int NFILT_DEF = 32;
    localparam int ADDRW     = 12;
    localparam int WORDW     = 32;
    localparam logic [ADDRW-1:0] BANK_BASE = 12'hA00;

    // Header / filter word layout (R2): base | srr | ide | ext | rtr
    typedef struct packed {
        logic [10:0] base;
        logic        srr;
        logic        ide;
        logic [17:0] ext;
        logic        rtr;
    } hdr_t;

    // Compare one header against one filter slot (R2, R3)
    function automatic logic hdr_match(hdr_t h, hdr_t m, hdr_t id);
        logic [WORDW-1:0] diff;
        if (!m.ide) begin
            return ((h.base ^ id.base) & m.base) == '0;
        end
        diff = (WORDW'(h) ^ WORDW'(id)) & WORDW'(m);
        return diff == '0;
    endfunction

endpackage

// File: rtl/canf_filter_regs.sv
module canf_filter_regs
    import canf_pkg::*;
#(
    parameter int NFILT = NFILT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [ADDRW-1:0] cfg_addr,
    input  logic [WORDW-1:0] cfg_wdata,
    output hdr_t             mask_o [NFILT],
    output hdr_t             id_o   [NFILT]
);
    localparam int IDXW      = $clog2(NFILT);
    localparam int BANKBYTES = NFILT * 8;

    logic [ADDRW-1:0] rel;
    logic             in_bank;
    logic [IDXW-1:0]  slot;
    logic             is_id;

    always_comb begin
        rel     = cfg_addr - BANK_BASE;
        in_bank = (cfg_addr >= BANK_BASE) && (int'(rel) < BANKBYTES) && (cfg_addr[1:0] == 2'b00);
        slot    = rel[IDXW+2:3];
        is_id   = rel[2];
    end

    for (genvar j = 0; j < NFILT; j++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_o[j] <= '0;
                id_o[j]   <= '0;
            end else if (cfg_we && in_bank && slot == IDXW'(j)) begin
                if (is_id) id_o[j]   <= hdr_t'(cfg_wdata);
                else       mask_o[j] <= hdr_t'(cfg_wdata);
            end
        end
    end
endmodule

// File: rtl/canf_match_bank.sv
module canf_match_bank
    import canf_pkg::*;
#(
    parameter int NFILT = NFILT_DEF
) (
    input  hdr_t             hdr,
    input  hdr_t             mask_i [NFILT],
    input  hdr_t             id_i   [NFILT],
    input  logic [NFILT-1:0] en,
    output logic [NFILT-1:0] hits
);
    for (genvar j = 0; j < NFILT; j++) begin : g_cmp
        assign hits[j] = en[j] && hdr_match(hdr, mask_i[j], id_i[j]);
    end
endmodule

// File: rtl/canf_route.sv
module canf_route
    import canf_pkg::*;
#(
    parameter int NFILT = NFILT_DEF,
    localparam int IDXW  = $clog2(NFILT),
    localparam int PARTW = IDXW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [NFILT-1:0] hits,
    input  logic [PARTW-1:0] part,
    input  logic             full0,
    input  logic             full1,
    output logic             store_o,
    output logic             drop_o,
    output logic             sel_o,
    output logic [IDXW-1:0]  idx_o
);
    logic            any_hit;
    logic [IDXW-1:0] win;
    logic            tgt;
    logic            tgt_full;

    // Lowest index wins (R5)
    always_comb begin
        any_hit = 1'b0;
        win     = '0;
        for (int j = NFILT - 1; j >= 0; j--) begin
            if (hits[j]) begin
                any_hit = 1'b1;
                win     = IDXW'(j);
            end
        end
        tgt      = !(PARTW'(win) < part);
        tgt_full = tgt ? full1 : full0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_o <= 1'b0;
            drop_o  <= 1'b0;
            sel_o   <= 1'b0;
            idx_o   <= '0;
        end else begin
            store_o <= valid && any_hit && !tgt_full;
            drop_o  <= valid && any_hit && tgt_full;
            if (valid && any_hit) begin
                sel_o <= tgt;
                idx_o <= win;
            end
        end
    end
endmodule

// File: rtl/canf_accept_filter.sv
module canf_accept_filter
    import canf_pkg::*;
#(
    parameter int NFILT = NFILT_DEF,
    localparam int IDXW  = $clog2(NFILT),
    localparam int PARTW = IDXW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [ADDRW-1:0] cfg_addr,
    input  logic [WORDW-1:0] cfg_wdata,
    input  logic             frm_valid,
    input  logic [10:0]      frm_base,
    input  logic             frm_srr,
    input  logic             frm_ide,
    input  logic [17:0]      frm_ext,
    input  logic             frm_rtr,
    input  logic [NFILT-1:0] flt_en,
    input  logic [PARTW-1:0] part_idx,
    input  logic             fifo0_full,
    input  logic             fifo1_full,
    output logic             store_o,
    output logic             fifo_sel_o,
    output logic [IDXW-1:0]  hit_idx_o,
    output logic             drop_o
);
    hdr_t             hdr;
    hdr_t             mask_w [NFILT];
    hdr_t             id_w   [NFILT];
    logic [NFILT-1:0] hits;

    always_comb begin
        hdr.base = frm_base;
        hdr.srr  = frm_srr;
        hdr.ide  = frm_ide;
        hdr.ext  = frm_ext;
        hdr.rtr  = frm_rtr;
    end

    canf_filter_regs #(.NFILT(NFILT)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mask_o(mask_w), .id_o(id_w)
    );

    canf_match_bank #(.NFILT(NFILT)) u_match (
        .hdr(hdr), .mask_i(mask_w), .id_i(id_w), .en(flt_en), .hits(hits)
    );

    canf_route #(.NFILT(NFILT)) u_route (
        .clk(clk), .rst(rst), .valid(frm_valid), .hits(hits), .part(part_idx),
        .full0(fifo0_full), .full1(fifo1_full), .store_o(store_o),
        .drop_o(drop_o), .sel_o(fifo_sel_o), .idx_o(hit_idx_o)
    );
endmodule

// File: rtl/canf_accept_chk.sv
module canf_accept_chk #(
    parameter int NFILT = 32,
    localparam int IDXW  = $clog2(NFILT),
    localparam int PARTW = IDXW + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             frm_valid,
    input logic [NFILT-1:0] flt_en,
    input logic [PARTW-1:0] part_idx,
    input logic             fifo0_full,
    input logic             fifo1_full,
    input logic             store_o,
    input logic             drop_o,
    input logic             fifo_sel_o,
    input logic [IDXW-1:0]  hit_idx_o
);
    logic [NFILT-1:0] en_q;
    always_ff @(posedge clk) en_q <= flt_en;

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(store_o && drop_o));

    a_r8_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (store_o || drop_o) |-> $past(frm_valid));

    a_r4_none_enabled: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && flt_en == '0) |=> !(store_o || drop_o));

    a_r4_slot_enabled: assert property (@(posedge clk) disable iff (rst)
        (store_o || drop_o) |-> en_q[hit_idx_o]);

    a_r6_route: assert property (@(posedge clk) disable iff (rst)
        (store_o || drop_o) |-> (fifo_sel_o == (PARTW'(hit_idx_o) >= $past(part_idx))));

    a_r7_store_room: assert property (@(posedge clk) disable iff (rst)
        store_o |-> !(fifo_sel_o ? $past(fifo1_full) : $past(fifo0_full)));

    a_r7_drop_full: assert property (@(posedge clk) disable iff (rst)
        drop_o |-> (fifo_sel_o ? $past(fifo1_full) : $past(fifo0_full)));
endmodule

bind canf_accept_filter canf_accept_chk #(.NFILT(NFILT)) u_chk (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .flt_en(flt_en),
    .part_idx(part_idx), .fifo0_full(fifo0_full), .fifo1_full(fifo1_full),
    .store_o(store_o), .drop_o(drop_o), .fifo_sel_o(fifo_sel_o),
    .hit_idx_o(hit_idx_o)
);

// File: tb/canf_accept_filter_bench.sv
module canf_accept_filter_bench;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frm_valid = 1'b0;
    logic [31:0] hdr = '0;
    logic [N-1:0] flt_en = '0;
    logic [5:0]  part_idx = '0;
    logic        fifo0_full = 1'b0;
    logic        fifo1_full = 1'b0;
    logic        store_o, fifo_sel_o, drop_o;
    logic [4:0]  hit_idx_o;

    always #2.5 clk = ~clk;

    canf_accept_filter u_canf_accept_filter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frm_valid(frm_valid),
        .frm_base(hdr[31:21]), .frm_srr(hdr[20]), .frm_ide(hdr[19]),
        .frm_ext(hdr[18:1]), .frm_rtr(hdr[0]), .flt_en(flt_en),
        .part_idx(part_idx), .fifo0_full(fifo0_full), .fifo1_full(fifo1_full),
        .store_o(store_o), .fifo_sel_o(fifo_sel_o), .hit_idx_o(hit_idx_o),
        .drop_o(drop_o)
    );

    typedef struct {
        int    kind;   // 0 none, 1 store, 2 drop
        int    sel;
        int    idx;
        int    due;
        string req;
    } exp_t;

    exp_t        q[$];
    exp_t        cur;
    int          tests = 0;
    int          fails = 0;
    int          cyc = 0;
    logic [31:0] sh_mask [N];
    logic [31:0] sh_id   [N];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                cur = q.pop_front();
                check(store_o == (cur.kind == 1) && drop_o == (cur.kind == 2), cur.req,
                      $sformatf("store/drop actual %0b/%0b expected kind %0d",
                                store_o, drop_o, cur.kind));
                if (cur.kind != 0) begin
                    check(fifo_sel_o == cur.sel[0], cur.req,
                          $sformatf("fifo_sel actual %0d expected %0d", fifo_sel_o, cur.sel));
                    check(hit_idx_o == cur.idx[4:0], cur.req,
                          $sformatf("hit_idx actual %0d expected %0d", hit_idx_o, cur.idx));
                end
            end else if (store_o || drop_o) begin
                check(1'b0, "R8", $sformatf("pulse without strobe: store %0b drop %0b expected 0/0",
                                            store_o, drop_o));
            end
        end
    end

    function automatic void model(input logic [31:0] h, input logic [N-1:0] en,
                                  input int part, input bit f0, input bit f1,
                                  output int kind, output int sel, output int idx);
        kind = 0; sel = 0; idx = 0;
        for (int j = 0; j < N; j++) begin
            bit ok;
            if (sh_mask[j][19] == 1'b0)
                ok = ((h[31:21] ^ sh_id[j][31:21]) & sh_mask[j][31:21]) == 0;
            else
                ok = ((h ^ sh_id[j]) & sh_mask[j]) == 0;
            if (en[j] && ok) begin
                idx  = j;
                sel  = (j < part) ? 0 : 1;
                kind = ((sel == 0) ? f0 : f1) ? 2 : 1;
                return;
            end
        end
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a >= 12'hA00 && a < 12'hA00 + N * 8 && a[1:0] == 2'b00) begin
            if (a[2]) sh_id[(a - 12'hA00) >> 3] = d;
            else      sh_mask[(a - 12'hA00) >> 3] = d;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: one frame per call, leaves the strobe high for back-to-back use
    task automatic frame(input logic [31:0] h, input logic [N-1:0] en, input int part,
                         input bit f0, input bit f1, input string req);
        exp_t e;
        @(negedge clk);
        hdr = h; flt_en = en; part_idx = 6'(part);
        fifo0_full = f0; fifo1_full = f1; frm_valid = 1'b1;
        model(h, en, part, f0, f1, e.kind, e.sel, e.idx);
        e.due = cyc + 1;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic expect_kind(input int k, input string req);
        if (q.size() > 0 && q[q.size()-1].kind != k)
            check(1'b0, req, $sformatf("bench model kind %0d expected %0d",
                                       q[q.size()-1].kind, k));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frm_valid = 1'b0;
        end
    endtask

    localparam logic [31:0] EXT_A = {11'h123, 1'b1, 1'b1, 18'h2ABCD, 1'b0};
    localparam logic [31:0] STD_B = {11'h456, 1'b0, 1'b0, 18'h0, 1'b0};

    initial begin
        for (int j = 0; j < N; j++) begin
            sh_mask[j] = '0;
            sh_id[j]   = '0;
        end
        repeat (3) @(negedge clk);
        check(!store_o && !drop_o, "R1", $sformatf("in reset store %0b drop %0b expected 0/0",
                                                   store_o, drop_o));
        rst = 1'b0;
        idle(1);
        // R1: cleared slot matches anything
        frame(32'hDEADBEEF, 32'h20, 32, 0, 0, "R1");
        expect_kind(1, "R1");
        idle(2);

        // R2 / R9: full extended compare on slot 3
        wr(12'hA18, 32'hFFFF_FFFF);
        wr(12'hA1C, EXT_A);
        frame(EXT_A, 32'h8, 32, 0, 0, "R2");
        expect_kind(1, "R2");
        frame(EXT_A ^ 32'h2, 32'h8, 32, 0, 0, "R2");
        expect_kind(0, "R2");
        frame(EXT_A ^ 32'h1, 32'h8, 32, 0, 0, "R2");
        expect_kind(0, "R2");
        idle(1);
        // R2: clear mask bit 1, ext bit 0 is ignored
        wr(12'hA18, 32'hFFFF_FFFD);
        frame(EXT_A ^ 32'h2, 32'h8, 32, 0, 0, "R2");
        expect_kind(1, "R2");
        idle(1);

        // R3: slot 4 standard-only compare
        wr(12'hA20, 32'hFFE0_0000);
        wr(12'hA24, STD_B);
        frame(STD_B | 32'h001F_FFFF, 32'h10, 32, 0, 0, "R3");
        expect_kind(1, "R3");
        frame(STD_B ^ 32'h0020_0000, 32'h10, 32, 0, 0, "R3");
        expect_kind(0, "R3");
        idle(1);

        // R5: slots 3 and 4 both match
        wr(12'hA20, 32'h0);
        frame(EXT_A, 32'h18, 32, 0, 0, "R5");
        expect_kind(1, "R5");
        frame(EXT_A, 32'h10, 32, 0, 0, "R5");
        expect_kind(1, "R5");
        idle(1);

        // R6: partition boundary
        frame(EXT_A, 32'h18, 4, 0, 0, "R6");
        frame(EXT_A, 32'h10, 4, 0, 0, "R6");
        frame(EXT_A, 32'h08, 0, 0, 0, "R6");
        frame(EXT_A, 32'h10, 32, 0, 0, "R6");
        frame(EXT_A, 32'h10, 40, 0, 0, "R6");
        idle(1);

        // R7: target full -> drop, no fallback
        frame(EXT_A, 32'h10, 4, 0, 1, "R7");
        expect_kind(2, "R7");
        frame(EXT_A, 32'h10, 4, 1, 0, "R7");
        expect_kind(1, "R7");
        frame(EXT_A, 32'h08, 4, 1, 0, "R7");
        expect_kind(2, "R7");
        idle(1);

        // R4: nothing enabled
        frame(EXT_A, 32'h0, 16, 0, 0, "R4");
        expect_kind(0, "R4");
        frame(EXT_A, 32'h0, 0, 1, 1, "R4");
        idle(3);

        // R9: ignored writes (unaligned, out of bank) leave slot 3 intact
        wr(12'hA1E, 32'h0);
        wr(12'hB18, 32'h0);
        wr(12'h918, 32'h0);
        frame(EXT_A ^ 32'h0100_0000, 32'h8, 32, 0, 0, "R9");
        expect_kind(0, "R9");
        // R9: last slot addresses
        wr(12'hAF8, 32'hFFE0_0000);
        wr(12'hAFC, STD_B);
        frame(STD_B, 32'h8000_0000, 32, 0, 0, "R9");
        expect_kind(1, "R9");
        idle(1);

        // R8: back-to-back random frames against random filters
        for (int j = 0; j < N; j++) begin
            logic [31:0] m;
            m = $urandom;
            if (j % 3 == 0) m = m & 32'hFFE0_0000;
            wr(12'hA00 + 12'(j * 8), m);
            wr(12'hA04 + 12'(j * 8), $urandom);
        end
        for (int i = 0; i < 400; i++) begin
            int j;
            logic [31:0] h;
            j = $urandom_range(N - 1);
            h = sh_id[j] ^ ($urandom & ~sh_mask[j]);
            if (i % 5 == 0) h = $urandom;
            frame(h, {$urandom} | {$urandom}, $urandom_range(36), $urandom_range(1),
                  $urandom_range(1), "R8");
            if (i % 7 == 0) idle(1);
        end
        idle(4);
        check(q.size() == 0, "R8", $sformatf("pending results actual %0d expected 0", q.size()));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R8: watchdog expired, actual hang expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule